// File: doc/BRIEF.md
# External Bus Chip-Select Decoder

This block sits between an on-chip master and an external memory bus. It holds eight region descriptors. Each descriptor gives a base address, a page size, an enable and a data-bus width. For every request the block compares the 32-bit internal address against all enabled regions at once. It then drives an active-low select line for each region that matches, and produces the 24-bit address seen by the external device.

When regions overlap, every matching select line goes low together. The width and lane behaviour come from the matching region with the lowest index. An address that matches no enabled region produces no select at all. Instead the block raises an abort that carries a code telling an instruction-fetch miss from a data miss.

Descriptors are loaded through a small write port that takes an index, a data word and a write enable. All decode results are registered, so they appear one clock after the request strobe and last for exactly that one cycle.

Top module: `xbus_cs_decoder`

## Requirements
- R1: After reset every region is disabled, so any request is answered with an abort and with all select lines high.
- R2: Outputs are valid in the cycle after a clock edge at which `reqValid` is high. After an edge with `reqValid` low, all select lines read high, `abortValid` reads 0, `abortVector` reads 0, `byteSelN` reads 2'b11, `busWide` reads 0 and `extAddr` reads 0.
- R3: With `cfgWe` high at a clock edge, region `cfgIdx` takes its fields from `cfgData`. Bits [31:20] are the base address bits 31..20, bits [3:2] are the page code, bit 1 selects a 16-bit bus and bit 0 is the enable. The new contents govern requests from the next edge on.
- R4: A region matches when it is enabled and the request address agrees with its base above the in-page bits. Page code 00 gives 1 MB (20 in-page bits), 01 gives 4 MB (22) and 10 gives 16 MB (24). Code 11 is reserved and behaves as 16 MB. Base bits inside the page are ignored.
- R5: A disabled region never drives its select line low and never prevents an abort.
- R6: Every matching region drives its select line (bit i of `csN` for region i) low together. `busWide`, the address masking and the lane selects follow the matching region with the lowest index.
- R7: `extAddr` carries the request address bits below the page size of the chosen region, with the higher bits zero. An address anywhere within the page is accepted and wraps onto a smaller device.
- R8: For a 16-bit region `extAddr[0]` is 0. For an 8-bit region it equals request address bit 0.
- R9: `byteSelN` is active low, with bit 0 for the low byte lane and bit 1 for the high lane. An 8-bit region gives 2'b10. A 16-bit region gives 2'b00 for a halfword request (`reqHalf`=1), 2'b10 for a byte at an even address and 2'b01 for a byte at an odd address.
- R10: A request that matches no region gives `abortValid`=1 with all select lines high, `extAddr`=0, `byteSelN`=2'b11 and `busWide`=0. `abortVector` is 8'h0C when `reqFetch`=1 and 8'h10 otherwise. Whenever `abortValid` is 0, `abortVector` is 0.
- R11: `busWide` is 1 exactly when the chosen region is configured for a 16-bit bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Region descriptor write enable |
| cfgIdx | input | 3 | Index of the region being written |
| cfgData | input | 32 | Descriptor fields: base [31:20], page code [3:2], wide [1], enable [0] |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | 32 | Internal request address |
| reqFetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| reqHalf | input | 1 | 1 for a halfword access, 0 for a byte |
| csN | output | 8 | Active-low select line per region |
| extAddr | output | 24 | External address |
| byteSelN | output | 2 | Active-low byte lane selects (bit 0 low lane) |
| busWide | output | 1 | Chosen region uses a 16-bit bus |
| abortValid | output | 1 | Request matched no enabled region |
| abortVector | output | 8 | 8'h0C fetch abort, 8'h10 data abort, else 0 |

## Verification
The bench sweeps every value of address bits 31..20 under two region layouts. Both layouts mix all four page codes, both bus widths, a disabled region and a pair of regions sharing one base. A varying in-page offset runs alongside the sweep, and the fetch and halfword flags toggle with it. Because the sweep covers every upper address value, it shows whether the compare masks the right number of bits for each page code. The overlapping pair shows whether the lowest index wins, and the disabled region shows whether the enable is honoured. The changing offsets and flags separate the wrap, A0 and lane-select behaviour and the two abort codes. Directed requests then pin down the reset state, the idle cycles between requests and single corner addresses.

// File: rtl/xbus_cs_pkg.sv
package xbus_cs_pkg;
  localparam int ADDR_W        = 32;
  localparam int EXT_W         = 24;
  localparam int MIN_PAGE_BITS = 20;
  localparam int BASE_W        = ADDR_W - MIN_PAGE_BITS;
  localparam logic [7:0] VEC_PREFETCH = 8'h0C;
  localparam logic [7:0] VEC_DATA     = 8'h10;

  typedef struct packed {
    logic [BASE_W-1:0] baseHi;
    logic [1:0]        pageCode;
    logic              wide;
    logic              enable;
  } regionCfg_t;

  typedef struct packed {
    logic decodeEn;
    logic isFetch;
    logic isHalf;
  } decStrobe_t;
endpackage

// File: rtl/xbus_cs_ctrl.sv
module xbus_cs_ctrl
  import xbus_cs_pkg::*;
#(
  parameter int NUM_CS = 8,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgWe,
  input  logic [SEL_W-1:0]              cfgIdx,
  input  logic [ADDR_W-1:0]             cfgData,
  input  logic                          reqValid,
  input  logic                          reqFetch,
  input  logic                          reqHalf,
  output regionCfg_t [NUM_CS-1:0]       cfgArr,
  output decStrobe_t                    strobe
);
  regionCfg_t [NUM_CS-1:0] cfgQ;
  regionCfg_t newCfg;
  logic [NUM_CS-1:0] enVec;

  always_comb begin
    newCfg.baseHi   = cfgData[ADDR_W-1:MIN_PAGE_BITS];
    newCfg.pageCode = cfgData[3:2];
    newCfg.wide     = cfgData[1];
    newCfg.enable   = cfgData[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= '0;
    else if (cfgWe) cfgQ[cfgIdx] <= newCfg;
  end

  assign cfgArr = cfgQ;

  always_comb begin
    strobe.decodeEn = reqValid;
    strobe.isFetch  = reqFetch;
    strobe.isHalf   = reqHalf;
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : gEn
    assign enVec[g] = cfgQ[g].enable;
  end

  AST_RESET_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> enVec == '0); // R1
  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> cfgArr[$past(cfgIdx)] == {$past(cfgData[ADDR_W-1:MIN_PAGE_BITS]), $past(cfgData[3:0])}); // R3
endmodule

// File: rtl/xbus_cs_datapath.sv
module xbus_cs_datapath
  import xbus_cs_pkg::*;
#(
  parameter int NUM_CS = 8,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  decStrobe_t              strobe,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  regionCfg_t [NUM_CS-1:0] cfgArr,
  output logic [NUM_CS-1:0]       csN,
  output logic [EXT_W-1:0]        extAddr,
  output logic [1:0]              byteSelN,
  output logic                    busWide,
  output logic                    abortValid,
  output logic [7:0]              abortVector
);
  logic [NUM_CS-1:0] hitVec;
  logic [BASE_W-1:0] hiMask [NUM_CS];
  logic [EXT_W-1:0]  loMask [NUM_CS];
  logic [SEL_W-1:0]  selIdx;
  logic              anyHit;
  regionCfg_t        selCfg;

  logic [NUM_CS-1:0] nxtCsN;
  logic [EXT_W-1:0]  nxtAddr;
  logic [1:0]        nxtBs;
  logic              nxtWide, nxtAb;
  logic [7:0]        nxtVec;

  // Per-region compare; extra in-page bits grow by 2 per page code step.
  for (genvar g = 0; g < NUM_CS; g++) begin : gRegion
    int unsigned extraBits;
    always_comb begin
      case (cfgArr[g].pageCode)
        2'b00:   extraBits = 0;
        2'b01:   extraBits = 2;
        default: extraBits = 4;
      endcase
      hiMask[g] = ~BASE_W'((32'd1 << extraBits) - 32'd1);
      loMask[g] = EXT_W'((32'd1 << (MIN_PAGE_BITS + extraBits)) - 32'd1);
      hitVec[g] = cfgArr[g].enable &&
                  (((reqAddr[ADDR_W-1:MIN_PAGE_BITS] ^ cfgArr[g].baseHi) & hiMask[g]) == '0);
    end
  end

  // Lowest index wins the attributes.
  always_comb begin
    selIdx = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (hitVec[i]) selIdx = SEL_W'(i);
    end
    anyHit = |hitVec;
    selCfg = cfgArr[selIdx];
  end

  always_comb begin
    nxtCsN  = '1;
    nxtAddr = '0;
    nxtBs   = 2'b11;
    nxtWide = 1'b0;
    nxtAb   = 1'b0;
    nxtVec  = '0;
    if (strobe.decodeEn) begin
      if (anyHit) begin
        nxtCsN  = ~hitVec;
        nxtAddr = reqAddr[EXT_W-1:0] & loMask[selIdx];
        nxtWide = selCfg.wide;
        if (selCfg.wide) begin
          nxtAddr[0] = 1'b0;
          if (strobe.isHalf)  nxtBs = 2'b00;
          else if (reqAddr[0]) nxtBs = 2'b01;
          else                nxtBs = 2'b10;
        end else begin
          nxtBs = 2'b10;
        end
      end else begin
        nxtAb  = 1'b1;
        nxtVec = strobe.isFetch ? VEC_PREFETCH : VEC_DATA;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csN         <= '1;
      extAddr     <= '0;
      byteSelN    <= 2'b11;
      busWide     <= 1'b0;
      abortValid  <= 1'b0;
      abortVector <= '0;
    end else begin
      csN         <= nxtCsN;
      extAddr     <= nxtAddr;
      byteSelN    <= nxtBs;
      busWide     <= nxtWide;
      abortValid  <= nxtAb;
      abortVector <= nxtVec;
    end
  end

  AST_ABORT_NO_CS: assert property (@(posedge clk) disable iff (!rstN)
    abortValid |-> csN == '1); // R10
  AST_ABORT_CODE: assert property (@(posedge clk) disable iff (!rstN)
    abortValid |-> (abortVector == VEC_PREFETCH || abortVector == VEC_DATA)); // R10
  AST_NO_CODE_WITHOUT_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    !abortValid |-> abortVector == '0); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.decodeEn) |-> (csN == '1 && !abortValid && byteSelN == 2'b11)); // R2
  AST_HIT_XOR_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobe.decodeEn)) |-> (abortValid != (csN != '1))); // R10
  AST_NARROW_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (csN != '1 && !busWide) |-> byteSelN == 2'b10); // R9
  AST_WIDE_A0: assert property (@(posedge clk) disable iff (!rstN)
    busWide |-> !extAddr[0]); // R8
endmodule

// File: rtl/xbus_cs_decoder.sv
module xbus_cs_decoder
  import xbus_cs_pkg::*;
#(
  parameter int NUM_CS = 8,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgIdx,
  input  logic [31:0]       cfgData,
  input  logic              reqValid,
  input  logic [31:0]       reqAddr,
  input  logic              reqFetch,
  input  logic              reqHalf,
  output logic [NUM_CS-1:0] csN,
  output logic [23:0]       extAddr,
  output logic [1:0]        byteSelN,
  output logic              busWide,
  output logic              abortValid,
  output logic [7:0]        abortVector
);
  regionCfg_t [NUM_CS-1:0] cfgArr;
  decStrobe_t              strobe;

  xbus_cs_ctrl #(.NUM_CS(NUM_CS)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .reqValid(reqValid), .reqFetch(reqFetch), .reqHalf(reqHalf),
    .cfgArr(cfgArr), .strobe(strobe)
  );

  xbus_cs_datapath #(.NUM_CS(NUM_CS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr), .cfgArr(cfgArr),
    .csN(csN), .extAddr(extAddr), .byteSelN(byteSelN), .busWide(busWide),
    .abortValid(abortValid), .abortVector(abortVector)
  );
endmodule

// File: tb/xbus_cs_decoder_tb_top.sv
module xbus_cs_decoder_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [2:0] cfgIdx = '0;
  logic [31:0] cfgData = '0;
  logic reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic reqFetch = 1'b0;
  logic reqHalf = 1'b0;
  logic [7:0] csN;
  logic [23:0] extAddr;
  logic [1:0] byteSelN;
  logic busWide, abortValid;
  logic [7:0] abortVector;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Bench mirror of region descriptors
  logic [11:0] mBase [8];
  logic [1:0]  mCode [8];
  logic        mWide [8];
  logic        mEn   [8];

  always #2 clk = ~clk;

  xbus_cs_decoder dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqFetch(reqFetch), .reqHalf(reqHalf),
    .csN(csN), .extAddr(extAddr), .byteSelN(byteSelN), .busWide(busWide),
    .abortValid(abortValid), .abortVector(abortVector)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (addr 0x%08h)", tag, act, exp, reqAddr);
    end
  endtask

  task automatic writeCfg(input int idx, input logic [11:0] base, input logic [1:0] code,
                          input logic wide, input logic en);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgIdx = 3'(idx);
    cfgData = {base, 16'h0, code, wide, en};
    @(negedge clk);
    cfgWe = 1'b0;
    mBase[idx] = base; mCode[idx] = code; mWide[idx] = wide; mEn[idx] = en;
  endtask

  task automatic model(input logic [31:0] a, input logic f, input logic h,
                       output logic [7:0] eCs, output logic [23:0] eAddr,
                       output logic [1:0] eBs, output logic eWide,
                       output logic eAb, output logic [7:0] eVec);
    int sel = -1;
    int shSel = 20;
    eCs = 8'hFF;
    for (int i = 0; i < 8; i++) begin
      int sh = (mCode[i] == 2'b00) ? 20 : (mCode[i] == 2'b01) ? 22 : 24;
      longint unsigned base = longint'(mBase[i]) << 20;
      if (mEn[i] && ((longint'(a) >> sh) == (base >> sh))) begin
        eCs[i] = 1'b0;
        if (sel < 0) begin sel = i; shSel = sh; end
      end
    end
    if (sel < 0) begin
      eAddr = '0; eBs = 2'b11; eWide = 1'b0; eAb = 1'b1;
      eVec = f ? 8'h0C : 8'h10;
    end else begin
      eAddr = 24'(longint'(a) % (64'd1 << shSel));
      eWide = mWide[sel];
      if (eWide) eAddr[0] = 1'b0;
      eBs = !eWide ? 2'b10 : h ? 2'b00 : (a[0] ? 2'b01 : 2'b10);
      eAb = 1'b0; eVec = 8'h00;
    end
  endtask

  // Issue one request and check every output one edge later.
  task automatic doReq(input logic [31:0] a, input logic f, input logic h, input string csTag);
    logic [7:0] eCs; logic [23:0] eAddr; logic [1:0] eBs;
    logic eWide, eAb; logic [7:0] eVec;
    model(a, f, h, eCs, eAddr, eBs, eWide, eAb, eVec);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqFetch = f; reqHalf = h;
    @(negedge clk);
    reqValid = 1'b0;
    chk(csTag, 32'(csN), 32'(eCs));
    chk("R7 extAddr", 32'(extAddr), 32'(eAddr));
    chk("R9 byteSelN", 32'(byteSelN), 32'(eBs));
    chk("R11 busWide", 32'(busWide), 32'(eWide));
    chk("R10 abortValid", 32'(abortValid), 32'(eAb));
    chk("R10 abortVector", 32'(abortVector), 32'(eVec));
  endtask

  task automatic chkIdle();
    @(negedge clk);
    chk("R2 idle csN", 32'(csN), 32'hFF);
    chk("R2 idle abort", 32'(abortValid), 32'h0);
    chk("R2 idle vector", 32'(abortVector), 32'h0);
    chk("R2 idle lanes", 32'(byteSelN), 32'h3);
    chk("R2 idle wide", 32'(busWide), 32'h0);
    chk("R2 idle addr", 32'(extAddr), 32'h0);
  endtask

  task automatic sweep(input int salt);
    for (int i = 0; i < 4096; i++) begin
      logic [31:0] a;
      a = {12'(i), 20'((i * 37 + salt) & 32'hFFFFF)};
      doReq(a, i[0], i[1], "R4 csN sweep");
      if ((i % 512) == 0) chkIdle();
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      mBase[i] = '0; mCode[i] = '0; mWide[i] = 1'b0; mEn[i] = 1'b0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    chkIdle();
    // R1: everything disabled after reset
    doReq(32'h0000_0000, 1'b0, 1'b0, "R1 csN after reset");
    chk("R1 data abort", 32'(abortVector), 32'h10);
    doReq(32'h1234_5678, 1'b1, 1'b1, "R1 csN after reset");
    chk("R1 fetch abort", 32'(abortVector), 32'h0C);

    // Layout A
    writeCfg(0, 12'h000, 2'b00, 1'b0, 1'b1);
    writeCfg(1, 12'h010, 2'b10, 1'b1, 1'b1);
    writeCfg(2, 12'h402, 2'b01, 1'b1, 1'b1); // base bit in page ignored
    writeCfg(3, 12'h500, 2'b00, 1'b1, 1'b0);
    writeCfg(4, 12'h600, 2'b00, 1'b0, 1'b1);
    writeCfg(5, 12'h600, 2'b01, 1'b1, 1'b1);
    writeCfg(6, 12'h800, 2'b11, 1'b0, 1'b1);
    writeCfg(7, 12'hFFF, 2'b00, 1'b1, 1'b1);
    chkIdle();
    sweep(32'h5A5A5);

    // Directed corners
    doReq(32'h5000_0040, 1'b0, 1'b0, "R5 disabled csN");
    chk("R5 disabled gives abort", 32'(abortValid), 32'h1);
    doReq(32'h6000_0011, 1'b0, 1'b1, "R6 overlap csN");
    chk("R6 overlap both low", 32'(csN), 32'hCF);
    chk("R6 lowest index narrow", 32'(busWide), 32'h0);
    chk("R8 narrow keeps A0", 32'(extAddr), 32'h000011);
    doReq(32'h6020_0011, 1'b0, 1'b0, "R6 only upper region");
    chk("R6 single high region", 32'(csN), 32'hDF);
    chk("R8 wide clears A0", 32'(extAddr), 32'h200010);
    doReq(32'h80AB_CDEF, 1'b1, 1'b0, "R4 reserved code");
    chk("R7 wrap 16MB", 32'(extAddr), 32'hABCDEF);
    doReq(32'hFFF0_0003, 1'b0, 1'b0, "R8 csN");
    chk("R8 wide A0 zero", 32'(extAddr), 32'h000002);
    chk("R9 odd byte high lane", 32'(byteSelN), 32'h1);
    chkIdle();

    // Layout B: rewrite regions
    writeCfg(4, 12'h600, 2'b00, 1'b0, 1'b0);
    writeCfg(1, 12'h013, 2'b00, 1'b0, 1'b1);
    writeCfg(3, 12'h500, 2'b01, 1'b1, 1'b1);
    writeCfg(0, 12'h600, 2'b10, 1'b1, 1'b1);
    doReq(32'h6000_0001, 1'b0, 1'b0, "R3 rewrite csN");
    chk("R3 new winner is wide", 32'(busWide), 32'h1);
    chk("R3 overlap of 0 and 5", 32'(csN), 32'hDE);
    sweep(32'h3C3C1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule